// File: doc/BRIEF.md
# Linear Range Edge Splitter

This block sits in the memory-request path of a core that is executing inside a protected region of linear address space. Each incoming request carries a linear address, a byte length of 1 to 64, and a flag marking it as an instruction fetch or a data access. The block compares that request with a protected window. Software configures the window as a base address and a size. The window covers `base` up to, but not including, `base + size`.

If a request lies wholly inside the window, or wholly outside it, the block forwards it as one sub-access. That sub-access carries an inside/outside flag. If a data request crosses one edge of the window, the block cuts it at that edge into two sub-accesses. The lower-address part is issued first, and each part carries its own flag, so that later permission logic can judge the two parts separately. If an instruction fetch crosses an edge, the block raises a protection fault for it and issues no sub-access. Requests, sub-accesses and faults each use a valid/ready handshake.

The block assumes that the window is at least 64 bytes long and that neither the window nor any access wraps past the top of the address space. Under those conditions a request crosses at most one edge.

Top module: `range_edge_splitter`

## Requirements
- R1: After reset `req_ready` is 1, and `sub_valid` and `fault_valid` are both 0.
- R2: A request whose bytes all lie in [base, base+size) produces exactly one sub-access. That sub-access has the request's address and length and `sub_inside` = 1. This holds for data (`req_fetch` = 0) and for fetches (`req_fetch` = 1).
- R3: A request whose bytes all lie outside the window produces exactly one sub-access. That sub-access has the request's address and length and `sub_inside` = 0.
- R4: A data request with addr < base < addr+len produces two sub-accesses. The first is (addr, base-addr, inside 0). The second is (base, remaining length, inside 1).
- R5: A data request with addr < base+size < addr+len produces two sub-accesses. The first is (addr, base+size-addr, inside 1). The second is (base+size, remaining length, inside 0).
- R6: The lower-address sub-access is presented first. The second sub-access appears only after the first is accepted. While `sub_ready` is 0, a presented sub-access stays valid and unchanged.
- R7: A fetch request that crosses an edge of the window raises `fault_valid` with `fault_addr` equal to the request address, and produces no sub-access. The fault stays presented until `fault_ready` is 1.
- R8: `req_ready` stays 0 from the accepting edge of a request until its last sub-access, or its fault, has been handed off.
- R9: The edges are exact. An access that ends at base-1 is outside. An access that starts at base+size is outside. A 1-byte access at base+size-1 is inside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | First address of the protected window |
| cfg_size | input | ADDR_W | Size of the protected window in bytes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Request linear address |
| req_len | input | LEN_W | Request length in bytes (1..MAX_LEN) |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| sub_valid | output | 1 | Sub-access present |
| sub_ready | input | 1 | Sub-access accepted downstream |
| sub_addr | output | ADDR_W | Sub-access address |
| sub_len | output | LEN_W | Sub-access length in bytes |
| sub_inside | output | 1 | 1 = sub-access lies inside the window |
| fault_valid | output | 1 | Straddling-fetch fault present |
| fault_ready | input | 1 | Fault accepted |
| fault_addr | output | ADDR_W | Address of the faulting fetch |

## Verification
Two functions can fall on the same clock edge: the handoff of the first half of a split, and the loading of the second half into the same output registers. To provoke this, the bench holds `sub_ready` high through a whole split. It then checks that the second half appears on the very next cycle with the right address, length and flag, that the first half is neither dropped nor repeated, and that `req_ready` stays low until the cycle after the second handoff. A separate scenario holds `sub_ready` low across a split to confirm that the first half is held and that the second half waits.

// File: rtl/range_split_pkg.sv
package range_split_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_HEAD  = 2'd1,
    S_TAIL  = 2'd2,
    S_FAULT = 2'd3
  } split_state_t;
endpackage

// File: rtl/range_edge_classify.sv
module range_edge_classify #(
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  output logic              straddle,
  output logic              head_inside,
  output logic [LEN_W-1:0]  head_len,
  output logic [LEN_W-1:0]  tail_len,
  output logic [ADDR_W-1:0] cut_addr
);
  localparam int WW = ADDR_W + 1;

  logic [WW-1:0] a_w, b_w, lim_w, end_w, cut_w, diff_w;
  logic          cross_lo, cross_hi, all_in;

  always_comb begin
    a_w      = {1'b0, addr};
    b_w      = {1'b0, base};
    lim_w    = b_w + {1'b0, size};
    end_w    = a_w + {{(WW-LEN_W){1'b0}}, len};
    cross_lo = (a_w < b_w) && (end_w > b_w);
    cross_hi = (a_w < lim_w) && (end_w > lim_w);
    all_in   = (a_w >= b_w) && (a_w < lim_w);
    straddle = cross_lo || cross_hi;
    if (cross_lo) begin
      cut_w       = b_w;
      head_inside = 1'b0;
    end else if (cross_hi) begin
      cut_w       = lim_w;
      head_inside = 1'b1;
    end else begin
      cut_w       = end_w;
      head_inside = all_in;
    end
    diff_w   = cut_w - a_w;
    head_len = diff_w[LEN_W-1:0];
    tail_len = len - head_len;
    cut_addr = cut_w[ADDR_W-1:0];
  end

  // R4/R5: a cut always leaves both parts non-empty
  always_comb begin
    if (straddle) begin
      a_r4_cut_nonempty: assert (head_len != '0 && head_len < len)
        else $error("cut produced an empty part");
    end
  end
endmodule

// File: rtl/range_split_seq.sv
module range_split_seq
  import range_split_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_fetch,
  input  logic              c_straddle,
  input  logic              c_head_inside,
  input  logic [LEN_W-1:0]  c_head_len,
  input  logic [LEN_W-1:0]  c_tail_len,
  input  logic [ADDR_W-1:0] c_cut_addr,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [LEN_W-1:0]  sub_len,
  output logic              sub_inside,
  output logic              fault_valid,
  input  logic              fault_ready,
  output logic [ADDR_W-1:0] fault_addr
);
  split_state_t      state;
  logic [ADDR_W-1:0] addr_q, tail_addr_q;
  logic [LEN_W-1:0]  len_q, tail_len_q;
  logic              in_q, tail_in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      addr_q      <= '0;
      len_q       <= '0;
      in_q        <= 1'b0;
      tail_addr_q <= '0;
      tail_len_q  <= '0;
      tail_in_q   <= 1'b0;
      fault_addr  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          if (req_fetch && c_straddle) begin
            fault_addr <= req_addr;
            state      <= S_FAULT;
          end else begin
            addr_q      <= req_addr;
            len_q       <= c_head_len;
            in_q        <= c_head_inside;
            tail_addr_q <= c_cut_addr;
            tail_len_q  <= c_tail_len;
            tail_in_q   <= !c_head_inside;
            state       <= c_straddle ? S_HEAD : S_TAIL;
          end
        end
        S_HEAD: if (sub_ready) begin
          addr_q <= tail_addr_q;
          len_q  <= tail_len_q;
          in_q   <= tail_in_q;
          state  <= S_TAIL;
        end
        S_TAIL:  if (sub_ready)   state <= S_IDLE;
        S_FAULT: if (fault_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign sub_valid   = (state == S_HEAD) || (state == S_TAIL);
  assign fault_valid = (state == S_FAULT);
  assign sub_addr    = addr_q;
  assign sub_len     = len_q;
  assign sub_inside  = in_q;

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    sub_valid && !sub_ready |=> sub_valid && $stable(sub_addr) && $stable(sub_len) && $stable(sub_inside));

  a_r6_tail_follows_head: assert property (@(posedge clk) disable iff (rst)
    (state == S_TAIL && $past(state) == S_HEAD) |-> sub_addr == $past(sub_addr) + ADDR_W'($past(sub_len)));

  a_r8_busy_blocks_req: assert property (@(posedge clk) disable iff (rst)
    (sub_valid || fault_valid) |-> !req_ready);

  a_r7_fault_hold: assert property (@(posedge clk) disable iff (rst)
    fault_valid && !fault_ready |=> fault_valid && $stable(fault_addr));

  a_r7_fault_no_sub: assert property (@(posedge clk) disable iff (rst)
    !(fault_valid && sub_valid));

  a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
    sub_valid |-> (sub_len != '0) && (sub_len <= LEN_W'(MAX_LEN)));
endmodule

// File: rtl/range_edge_splitter.sv
module range_edge_splitter #(
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_fetch,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [LEN_W-1:0]  sub_len,
  output logic              sub_inside,
  output logic              fault_valid,
  input  logic              fault_ready,
  output logic [ADDR_W-1:0] fault_addr
);
  logic              c_straddle, c_head_inside;
  logic [LEN_W-1:0]  c_head_len, c_tail_len;
  logic [ADDR_W-1:0] c_cut_addr;

  range_edge_classify #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_classify (
    .addr(req_addr), .len(req_len), .base(cfg_base), .size(cfg_size),
    .straddle(c_straddle), .head_inside(c_head_inside),
    .head_len(c_head_len), .tail_len(c_tail_len), .cut_addr(c_cut_addr)
  );

  range_split_seq #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_fetch(req_fetch),
    .c_straddle(c_straddle), .c_head_inside(c_head_inside),
    .c_head_len(c_head_len), .c_tail_len(c_tail_len), .c_cut_addr(c_cut_addr),
    .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_addr(sub_addr), .sub_len(sub_len), .sub_inside(sub_inside),
    .fault_valid(fault_valid), .fault_ready(fault_ready), .fault_addr(fault_addr)
  );
endmodule

// File: tb/sim_range_edge_splitter.sv
`timescale 1ns/1ps
module sim_range_edge_splitter;
  localparam int AW = 32;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfg_base = 32'h1000;
  logic [AW-1:0] cfg_size = 32'h1000;
  logic          req_valid = 1'b0, req_fetch = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = 7'd1;
  logic          sub_ready = 1'b0, fault_ready = 1'b0;
  logic          req_ready, sub_valid, sub_inside, fault_valid;
  logic [AW-1:0] sub_addr, fault_addr;
  logic [LW-1:0] sub_len;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  range_edge_splitter u0 (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_fetch(req_fetch),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_len(sub_len), .sub_inside(sub_inside),
    .fault_valid(fault_valid), .fault_ready(fault_ready), .fault_addr(fault_addr)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      summary();
      $finish;
    end
  end

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic send(logic [AW-1:0] a, logic [LW-1:0] l, logic f);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_fetch = f;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // at a negedge: check the presented sub-access, then hand it off
  task automatic take(string rq, logic [AW-1:0] a, logic [LW-1:0] l, logic ins);
    chk(rq, "sub_valid", sub_valid, 1);
    chk(rq, "sub_addr", sub_addr, a);
    chk(rq, "sub_len", sub_len, l);
    chk(rq, "sub_inside", sub_inside, ins);
    sub_ready = 1'b1;
    @(negedge clk);
    sub_ready = 1'b0;
  endtask

  task automatic expect_idle(string rq);
    chk(rq, "sub_valid idle", sub_valid, 0);
    chk(rq, "req_ready idle", req_ready, 1);
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "sub_valid", sub_valid, 0);
    chk("R1", "fault_valid", fault_valid, 0);
  endtask

  task automatic t_single();
    send(32'h1100, 7'd16, 1'b0); take("R2", 32'h1100, 7'd16, 1); expect_idle("R2");
    send(32'h1200, 7'd4, 1'b1);  take("R2", 32'h1200, 7'd4, 1);  expect_idle("R2");
    send(32'h3000, 7'd8, 1'b0);  take("R3", 32'h3000, 7'd8, 0);  expect_idle("R3");
    send(32'h0100, 7'd64, 1'b1); take("R3", 32'h0100, 7'd64, 0); expect_idle("R3");
  endtask

  task automatic t_splits();
    send(32'h0FF8, 7'd16, 1'b0);
    take("R4", 32'h0FF8, 7'd8, 0);
    take("R4", 32'h1000, 7'd8, 1);
    expect_idle("R4");
    send(32'h1FF0, 7'd64, 1'b0);
    take("R5", 32'h1FF0, 7'd16, 1);
    take("R5", 32'h2000, 7'd48, 0);
    expect_idle("R5");
  endtask

  task automatic t_edges();
    send(32'h0FC0, 7'd64, 1'b0); take("R9", 32'h0FC0, 7'd64, 0); expect_idle("R9");
    send(32'h2000, 7'd1, 1'b0);  take("R9", 32'h2000, 7'd1, 0);  expect_idle("R9");
    send(32'h1FFF, 7'd1, 1'b0);  take("R9", 32'h1FFF, 7'd1, 1);  expect_idle("R9");
    send(32'h0FFF, 7'd2, 1'b0);
    take("R9", 32'h0FFF, 7'd1, 0);
    take("R9", 32'h1000, 7'd1, 1);
  endtask

  // first half stalled; an extra request is offered and must wait
  task automatic t_stall();
    send(32'h0FFC, 7'd12, 1'b0);
    req_valid = 1'b1; req_addr = 32'h1500; req_len = 7'd2; req_fetch = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R6", "held valid", sub_valid, 1);
      chk("R6", "held addr", sub_addr, 32'h0FFC);
      chk("R6", "held len", sub_len, 7'd4);
      chk("R8", "req_ready busy", req_ready, 0);
      @(negedge clk);
    end
    take("R6", 32'h0FFC, 7'd4, 0);
    chk("R8", "req_ready busy tail", req_ready, 0);
    take("R6", 32'h1000, 7'd8, 1);
    // the queued request is accepted only now
    chk("R8", "req_ready after last", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    take("R8", 32'h1500, 7'd2, 1);
    expect_idle("R8");
  endtask

  // handoff of first half and load of second half on the same edge
  task automatic t_back_to_back();
    send(32'h1FE0, 7'd40, 1'b0);
    sub_ready = 1'b1;
    chk("R6", "b2b head addr", sub_addr, 32'h1FE0);
    chk("R6", "b2b head len", sub_len, 7'd32);
    chk("R6", "b2b head in", sub_inside, 1);
    @(negedge clk);
    chk("R6", "b2b tail valid", sub_valid, 1);
    chk("R6", "b2b tail addr", sub_addr, 32'h2000);
    chk("R6", "b2b tail len", sub_len, 7'd8);
    chk("R6", "b2b tail in", sub_inside, 0);
    chk("R8", "b2b busy", req_ready, 0);
    @(negedge clk);
    sub_ready = 1'b0;
    expect_idle("R6");
  endtask

  task automatic t_fault();
    send(32'h1FFC, 7'd8, 1'b1);
    for (int i = 0; i < 2; i++) begin
      chk("R7", "fault_valid", fault_valid, 1);
      chk("R7", "fault_addr", fault_addr, 32'h1FFC);
      chk("R7", "no sub", sub_valid, 0);
      chk("R8", "busy on fault", req_ready, 0);
      @(negedge clk);
    end
    fault_ready = 1'b1;
    @(negedge clk);
    fault_ready = 1'b0;
    chk("R7", "fault cleared", fault_valid, 0);
    expect_idle("R7");
    send(32'h0FF0, 7'd32, 1'b1);
    chk("R7", "low-edge fault", fault_valid, 1);
    chk("R7", "low-edge addr", fault_addr, 32'h0FF0);
    fault_ready = 1'b1;
    @(negedge clk);
    fault_ready = 1'b0;
    expect_idle("R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_splits();
    t_edges();
    t_stall();
    t_back_to_back();
    t_fault();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule